// File: doc/BRIEF.md
# Per-Line XOR Address Bus Encoder and Decoder

This block cuts switching on the least significant lines of an instruction address bus while the fetch stream runs sequentially. Each of the lowest `ENC_W` lines is coded on its own. The coded bit is the line's current value XORed with earlier values of that same line. The tap distance follows from the period of the line in a binary count: line `i` repeats every `2^(i+1)` samples. Lines above `ENC_W` are registered and sent as they are.

An elaboration parameter picks one of two codes. In the full-window code, the bit sent is the parity of one whole period of the line, which is the current sample and the `2^(i+1)-1` samples before it. In the half-period code, the bit sent is the current sample XOR the sample taken `2^i` cycles earlier. The half-period code has a single XOR in front of the register whatever the line, and it settles after a jump in half the samples. The matching decoder sits at the far side of the registered bus. It rebuilds each line by XORing the received bit with the same taps taken from its own history of decoded bits. Both histories clear on reset, so the two ends begin in step. `ENC_W` may be 1, 2 or 3 and must be below `ADDR_W`.

Top module: `addr_xor_codec`

## Requirements
- R1: While `rst_n` is low, every history bit clears, and after the next rising clock edge `bus_out` and `addr_out` both read 0 whatever `addr_in` carries.
- R2: `addr_in` is sampled on the rising edge. A change on `addr_in` between edges has no effect on `bus_out` or `addr_out` until the next edge.
- R3: `bus_out[ADDR_W-1:ENC_W]` equals `addr_in[ADDR_W-1:ENC_W]` as sampled at the previous edge.
- R4: In full-window mode (`MODE = WIN_FULL`), `bus_out[i]` for `i < ENC_W` is the parity of bit `i` over the latest sample and the `2^(i+1)-1` samples before it. Samples from before reset count as 0.
- R5: In half-period mode (`MODE = WIN_HALF`), `bus_out[i]` for `i < ENC_W` is bit `i` of the latest sample XOR bit `i` of the sample taken `2^i` samples earlier. Samples from before reset count as 0.
- R6: `addr_out` equals the address sampled at the previous edge, in the same cycle that its code is on `bus_out`.
- R7: In full-window mode, once the last `2^ENC_W - 1` steps between samples have each been +1 (modulo `2^ADDR_W`), the low field `bus_out[ENC_W-1:0]` reads 1: bit 0 is set and the other low bits are clear.
- R8: In half-period mode, once the last `2^(ENC_W-1)` steps have each been +1, every bit of `bus_out[ENC_W-1:0]` reads 1.
- R9: For as long as the sequential run continues past that point, `bus_out[ENC_W-1:0]` does not toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | ADDR_W | Address from the fetch logic |
| bus_out | output | ADDR_W | Registered coded bus: coded low field, plain upper field |
| addr_out | output | ADDR_W | Address rebuilt by the decoder from `bus_out` |

## Verification
Every result is due one rising edge after the address that causes it. This holds for the coded low field, the plain upper field and the rebuilt address, since the decoder adds no register of its own. The bench drives each address on a falling edge and checks the outputs on the next falling edge against the sample list it has kept. A second look 1 ns after a drive confirms that nothing moves before that edge. The quiet-bus checks key on a count of consecutive +1 steps that the bench keeps for itself. The checker keeps a separate count and expects the constant low field only once that count covers the widest window.

// File: rtl/codec_pkg.sv
package codec_pkg;

  typedef enum logic {
    WIN_FULL = 1'b0,
    WIN_HALF = 1'b1
  } win_mode_e;

  // counting period of address line pos
  function automatic int line_period(input int pos);
    return 1 << (pos + 1);
  endfunction

  // number of past samples a line keeps
  function automatic int hist_depth(input int pos, input win_mode_e mode);
    return (mode == WIN_FULL) ? line_period(pos) - 1 : line_period(pos) / 2;
  endfunction

  // consecutive +1 steps needed before the low field goes quiet
  function automatic int quiet_steps(input int width, input win_mode_e mode);
    return (mode == WIN_FULL) ? (1 << width) - 1 : 1 << (width - 1);
  endfunction

  // low-field value held during a long sequential run
  function automatic int quiet_word(input int width, input win_mode_e mode);
    return (mode == WIN_FULL) ? 1 : (1 << width) - 1;
  endfunction

endpackage

// File: rtl/tap_history.sv
module tap_history #(
  parameter int DEPTH    = 1,
  parameter bit FOLD_ALL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic fold
);
  logic [DEPTH-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else begin
      taps[0] <= bit_in;
      for (int k = 1; k < DEPTH; k++) begin
        taps[k] <= taps[k-1];
      end
    end
  end

  generate
    if (FOLD_ALL) begin : g_parity
      assign fold = ^taps;
    end else begin : g_oldest
      assign fold = taps[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/enc_lane.sv
module enc_lane
  import codec_pkg::*;
#(
  parameter int        POS  = 0,
  parameter win_mode_e MODE = WIN_FULL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x_in,
  output logic y_q
);
  localparam int DEPTH = hist_depth(POS, MODE);

  logic fold;
  logic y_d;

  tap_history #(
    .DEPTH   (DEPTH),
    .FOLD_ALL(MODE == WIN_FULL)
  ) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_in(x_in),
    .fold  (fold)
  );

  assign y_d = x_in ^ fold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= 1'b0;
    else        y_q <= y_d;
  end
endmodule

// File: rtl/dec_lane.sv
module dec_lane
  import codec_pkg::*;
#(
  parameter int        POS  = 0,
  parameter win_mode_e MODE = WIN_FULL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic y_in,
  output logic x_out
);
  localparam int DEPTH = hist_depth(POS, MODE);

  logic fold;

  tap_history #(
    .DEPTH   (DEPTH),
    .FOLD_ALL(MODE == WIN_FULL)
  ) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_in(x_out),
    .fold  (fold)
  );

  assign x_out = y_in ^ fold;
endmodule

// File: rtl/addr_xor_codec.sv
module addr_xor_codec
  import codec_pkg::*;
#(
  parameter int        ADDR_W = 16,
  parameter int        ENC_W  = 3,
  parameter win_mode_e MODE   = WIN_FULL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] bus_out,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int PASS_W = ADDR_W - ENC_W;

  logic [ENC_W-1:0]  low_enc_q;
  logic [ENC_W-1:0]  low_dec;
  logic [PASS_W-1:0] pass_q;

  generate
    for (genvar i = 0; i < ENC_W; i++) begin : g_line
      enc_lane #(.POS(i), .MODE(MODE)) u_enc (
        .clk  (clk),
        .rst_n(rst_n),
        .x_in (addr_in[i]),
        .y_q  (low_enc_q[i])
      );
      dec_lane #(.POS(i), .MODE(MODE)) u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .y_in (low_enc_q[i]),
        .x_out(low_dec[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pass_q <= '0;
    else        pass_q <= addr_in[ADDR_W-1:ENC_W];
  end

  assign bus_out  = {pass_q, low_enc_q};
  assign addr_out = {pass_q, low_dec};
endmodule

// File: rtl/addr_xor_codec_chk.sv
module addr_xor_codec_chk
  import codec_pkg::*;
#(
  parameter int        ADDR_W = 16,
  parameter int        ENC_W  = 3,
  parameter win_mode_e MODE   = WIN_FULL
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] bus_out,
  input logic [ADDR_W-1:0] addr_out
);
  localparam int             NEED  = quiet_steps(ENC_W, MODE);
  localparam logic [ENC_W-1:0] QUIET = ENC_W'(quiet_word(ENC_W, MODE));

  logic              primed;
  logic [ADDR_W-1:0] prev_in;
  logic [3:0]        steps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      prev_in <= '0;
      steps   <= '0;
    end else begin
      primed  <= 1'b1;
      prev_in <= addr_in;
      if (primed && addr_in == ADDR_W'(prev_in + 1'b1)) begin
        if (steps != 4'hF) steps <= steps + 4'd1;
      end else begin
        steps <= '0;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (bus_out == '0 && addr_out == '0)); // R1

  AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> bus_out[ADDR_W-1:ENC_W] == $past(addr_in[ADDR_W-1:ENC_W])); // R3

  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> addr_out == $past(addr_in)); // R6

  generate
    if (MODE == WIN_FULL) begin : g_full
      AST_QUIET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(steps) >= NEED) |-> bus_out[ENC_W-1:0] == QUIET); // R7
    end else begin : g_half
      AST_QUIET_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(steps) >= NEED) |-> bus_out[ENC_W-1:0] == QUIET); // R8
    end
  endgenerate

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(steps) > NEED) |-> $stable(bus_out[ENC_W-1:0])); // R9
endmodule

bind addr_xor_codec addr_xor_codec_chk #(
  .ADDR_W(ADDR_W),
  .ENC_W (ENC_W),
  .MODE  (MODE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr_in (addr_in),
  .bus_out (bus_out),
  .addr_out(addr_out)
);

// File: tb/tb_addr_xor_codec.sv
module tb_addr_xor_codec;
  import codec_pkg::*;

  localparam int AW   = 12;
  localparam int WF   = 3;
  localparam int WH   = 2;
  localparam int NMAX = 9000;
  localparam int AMOD = 1 << AW;

  logic          clk   = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] bus_f, out_f, bus_h, out_h;

  int samp  [NMAX];
  int runlen[NMAX];
  int nsamp = 0;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  addr_xor_codec #(.ADDR_W(AW), .ENC_W(WF), .MODE(WIN_FULL)) dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .bus_out(bus_f), .addr_out(out_f)
  );

  addr_xor_codec #(.ADDR_W(AW), .ENC_W(WH), .MODE(WIN_HALF)) dut_h (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .bus_out(bus_h), .addr_out(out_h)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s sample=%0d actual=%0h expected=%0h", req, nsamp - 1, act, exp);
    end
  endtask

  function automatic int bit_of(input int n, input int i);
    return (n < 0) ? 0 : (samp[n] >> i) & 1;
  endfunction

  // parity of one full period of line i, counted as a number of ones
  function automatic int win_code(input int n, input int w);
    int word = 0;
    for (int i = 0; i < w; i++) begin
      int ones = 0;
      for (int k = 0; k < (2 << i); k++) ones += bit_of(n - k, i);
      word |= (ones % 2) << i;
    end
    return word;
  endfunction

  function automatic int half_code(input int n, input int w);
    int word = 0;
    for (int i = 0; i < w; i++) begin
      int same = (bit_of(n, i) == bit_of(n - (1 << i), i)) ? 1 : 0;
      word |= (1 - same) << i;
    end
    return word;
  endfunction

  task automatic check_sample(input int n);
    int prev_f;
    int prev_h;
    chk("R4 full-window low field", 32'(bus_f[WF-1:0]), 32'(win_code(n, WF)));
    chk("R5 half-period low field", 32'(bus_h[WH-1:0]), 32'(half_code(n, WH)));
    chk("R3 upper field full", 32'(bus_f[AW-1:WF]), 32'(samp[n] >> WF));
    chk("R3 upper field half", 32'(bus_h[AW-1:WH]), 32'(samp[n] >> WH));
    chk("R6 decoded full", 32'(out_f), 32'(samp[n]));
    chk("R6 decoded half", 32'(out_h), 32'(samp[n]));
    if (runlen[n] >= 7) chk("R7 full quiet word", 32'(bus_f[WF-1:0]), 32'd1);
    if (runlen[n] >= 2) chk("R8 half quiet word", 32'(bus_h[WH-1:0]), 32'd3);
    prev_f = win_code(n - 1, WF);
    prev_h = half_code(n - 1, WH);
    if (runlen[n] >= 8) chk("R9 full no toggle", 32'(bus_f[WF-1:0]), 32'(prev_f));
    if (runlen[n] >= 3) chk("R9 half no toggle", 32'(bus_h[WH-1:0]), 32'(prev_h));
  endtask

  // caller stands on a falling edge for the first sample
  task automatic step(input int a);
    if (nsamp < NMAX) begin
      if (nsamp > 0) begin
        @(negedge clk);
        check_sample(nsamp - 1);
      end
      addr_in = AW'(a);
      samp[nsamp] = a % AMOD;
      if (nsamp > 0 && samp[nsamp] == (samp[nsamp-1] + 1) % AMOD)
        runlen[nsamp] = runlen[nsamp-1] + 1;
      else
        runlen[nsamp] = 0;
      nsamp++;
      #1;
      if (nsamp > 1) chk("R2 no change before edge", 32'(out_f), 32'(samp[nsamp-2]));
    end
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    addr_in = 12'hA5C;
    repeat (3) @(negedge clk);
    chk("R1 reset bus full", 32'(bus_f), 32'd0);
    chk("R1 reset decode full", 32'(out_f), 32'd0);
    chk("R1 reset bus half", 32'(bus_h), 32'd0);
    chk("R1 reset decode half", 32'(out_h), 32'd0);
    rst_n = 1'b1;

    // full sequential sweep, crossing the wrap back to zero
    for (int a = 0; a < AMOD + 10; a++) step(a);

    // held address: no +1 steps, the low field must still follow the code
    for (int k = 0; k < 20; k++) step(12'h3F0);

    // two regions touched in turn
    for (int k = 0; k < 30; k++) step((k % 2 == 0) ? 12'h100 + k : 12'h800 + k);

    // run across the top of the address space
    for (int a = AMOD - 6; a < AMOD + 9; a++) step(a);

    // random sequential runs separated by jumps
    for (int s = 0; s < 450; s++) begin
      int base = $urandom % AMOD;
      int len  = 1 + ($urandom % 14);
      for (int k = 0; k < len; k++) step(base + k);
    end

    @(negedge clk);
    check_sample(nsamp - 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule